// File: doc/BRIEF.md
# JTAG Debug Port Access Engine

This block is the debug-port end of a JTAG link. An external probe drives the four JTAG pins. It selects one of four scan chains through a 4-bit instruction register: a 32-bit identification code, a 1-bit bypass, and a 35-bit access chain that is shared by debug-port and access-port transfers. Every access scan sends in a command, made of a read/write flag, two register address bits and 32 data bits. The same scan returns a 3-bit acknowledge and 32 bits of earlier read data.

Debug-port commands act on three local registers. The first is a power and error control register. The second is a selector that picks the access port, the access-port register bank and the debug-port bank. The third is a read buffer. Access-port commands go out on a simple request/acknowledge register bus. Access-port reads are posted: the value comes back in the capture of a later scan, or through a read of the read buffer. A scan that arrives while a bus transfer is still open gets a WAIT acknowledge and is dropped. A faulting transfer sets a sticky error, and access-port traffic stays blocked until the probe clears it. All logic runs on `tck` with the asynchronous reset `trst_n`.

Top module: `jtag_dp_engine`

## Requirements
- R1: The instruction register is 4 bits wide, and Capture-IR loads 4'b0001. The opcodes are 4'hA debug-port access, 4'hB access-port access, 4'hE identification and 4'hF bypass, and every other opcode selects bypass. Test-Logic-Reset selects the identification opcode.
- R2: The identification chain shifts out the 32-bit IDCODE parameter, LSB first. The bypass chain captures 0 and passes tdi to tdo one shift later.
- R3: The access chain is 35 bits wide. Bit 0 is the read flag (1 = read), bits [2:1] hold register address bits A[3:2], and bits [34:3] hold data. At capture, bits [2:0] return the acknowledge, with 3'b010 meaning accepted, and bits [34:3] return the current read buffer.
- R4: While an access-port bus transfer is outstanding, a scan captures acknowledge 3'b001 (WAIT), and the command it carries is discarded.
- R5: The debug-port registers are control/status at A=1 (0x4) in debug-port bank 0 only, the selector at A=2 (0x8) and the read buffer at A=3 (0xC). A=0, or A=1 in a nonzero bank, reads 0 and ignores writes. A debug-port read result appears in the capture of the next access scan.
- R6: The selector holds the access-port number in [31:24], the access-port bank in [7:4] and the debug-port bank in [3:0], and it reads back in the same layout. A bus transfer carries ap_sel = the access-port number and ap_addr = {bank, A[3:2], 2'b00}.
- R7: Access-port reads are posted. The capture of the next scan returns the previous access-port read data, and reading the read buffer returns that data again without starting a bus transfer.
- R8: Each accepted access-port command makes exactly one bus transfer. ap_req stays high, with ap_sel, ap_addr and ap_wdata stable, until ap_ack is sampled high, and then drops.
- R9: Control/status bit 28 is the debug power request and bit 30 is the system power request. Each drives its output pin. Bits 29 and 31 read the matching acknowledge inputs, so requesting both powers with both acknowledged reads 0xF0000000. Both requests are 0 after reset.
- R10: ap_err sampled with ap_ack sets control/status bit 5. Writing 1 to bit 5 clears it. While bit 5 is set, access-port commands are accepted with 3'b010 but start no transfer and leave the read buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out; LSB of the active shift register in Shift states, otherwise 0 |
| ap_req | output | 1 | Access-port transfer request, held until acknowledged |
| ap_wr | output | 1 | 1 for a write transfer, 0 for a read |
| ap_sel | output | 8 | Access-port number taken from the selector |
| ap_addr | output | 8 | Access-port byte address {bank, A[3:2], 2'b00} |
| ap_wdata | output | 32 | Write data of the transfer |
| ap_ack | input | 1 | Transfer completion, one cycle |
| ap_rdata | input | 32 | Read data, valid with ap_ack |
| ap_err | input | 1 | Transfer fault, valid with ap_ack |
| sys_pwr_req | output | 1 | System power-up request |
| sys_pwr_ack | input | 1 | System power-up acknowledge |
| dbg_pwr_req | output | 1 | Debug power-up request |
| dbg_pwr_ack | input | 1 | Debug power-up acknowledge |

## Verification
The bench targets the one-scan lag of posted reads. A design that returned fresh data too early, or that started a bus transfer on a read-buffer read, would show the wrong capture value or an extra transfer. It overlaps a scan with a slow transfer to confirm that WAIT is returned and the dropped write never reaches storage. It also walks the sticky-error path, where a design that kept issuing transfers or overwrote the read buffer would be caught through the transfer count and the read buffer. Banked control/status access, bypass for unlisted opcodes and a random mix of selector and access-port traffic close the set.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

    typedef enum logic [3:0] {
        TAP_RESET,  TAP_IDLE,
        TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PA_DR, TAP_EX2_DR, TAP_UP_DR,
        TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PA_IR, TAP_EX2_IR, TAP_UP_IR
    } tap_state_e;

    localparam int IR_W       = 4;
    localparam int ACK_W      = 3;
    localparam int ADDR_W     = 2;
    localparam int STICKY_BIT = 5;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
    localparam logic [IR_W-1:0] OP_DPACC   = 4'hA;
    localparam logic [IR_W-1:0] OP_APACC   = 4'hB;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'hE;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;

    localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
    localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

endpackage

// File: rtl/jdp_tap_fsm.sv
module jdp_tap_fsm
    import jdp_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    tap_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TAP_RESET:  state_d = tms ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   state_d = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: state_d = tms ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: state_d = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  state_d = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: state_d = tms ? TAP_UP_DR  : TAP_PA_DR;
            TAP_PA_DR:  state_d = tms ? TAP_EX2_DR : TAP_PA_DR;
            TAP_EX2_DR: state_d = tms ? TAP_UP_DR  : TAP_SH_DR;
            TAP_UP_DR:  state_d = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: state_d = tms ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: state_d = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  state_d = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: state_d = tms ? TAP_UP_IR  : TAP_PA_IR;
            TAP_PA_IR:  state_d = tms ? TAP_EX2_IR : TAP_PA_IR;
            TAP_EX2_IR: state_d = tms ? TAP_UP_IR  : TAP_SH_IR;
            TAP_UP_IR:  state_d = tms ? TAP_SEL_DR : TAP_IDLE;
            default:    state_d = TAP_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= TAP_RESET;
        else         state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/jdp_scan_path.sv
module jdp_scan_path
    import jdp_pkg::*;
#(
    parameter int              DATA_W = 32,
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] IDCODE = 32'h2C6A_90B3
) (
    input  logic                    tck,
    input  logic                    trst_n,
    input  tap_state_e              state_i,
    input  logic                    tdi,
    output logic                    tdo,
    input  logic [ACK_W-1:0]        cap_ack_i,
    input  logic [DATA_W-1:0]       cap_data_i,
    output logic                    acc_cap_o,
    output logic                    acc_upd_o,
    output logic                    is_ap_o,
    output logic [DATA_W+ACK_W-1:0] scan_o
);

    localparam int ACC_W = DATA_W + ACK_W;
    localparam int PAD_W = ACC_W - ID_W;

    typedef struct packed {
        logic [IR_W-1:0]  ir;
        logic [IR_W-1:0]  ir_sr;
        logic [ACC_W-1:0] sr;
    } scan_t;

    scan_t s_d, s_q;
    logic  acc_sel, id_sel;

    always_comb begin
        acc_sel = 1'b0;
        id_sel  = 1'b0;
        case (s_q.ir)
            OP_DPACC, OP_APACC: acc_sel = 1'b1;
            OP_IDCODE:          id_sel  = 1'b1;
            OP_BYPASS:          ;
            default:            ;
        endcase
    end

    always_comb begin
        s_d = s_q;
        unique case (state_i)
            TAP_RESET:  s_d.ir    = OP_IDCODE;
            TAP_CAP_IR: s_d.ir_sr = IR_CAPTURE;
            TAP_SH_IR:  s_d.ir_sr = {tdi, s_q.ir_sr[IR_W-1:1]};
            TAP_UP_IR:  s_d.ir    = s_q.ir_sr;
            TAP_CAP_DR: begin
                if (acc_sel)     s_d.sr = {cap_data_i, cap_ack_i};
                else if (id_sel) s_d.sr = {{PAD_W{1'b0}}, IDCODE};
                else             s_d.sr = '0;
            end
            TAP_SH_DR: begin
                if (acc_sel)     s_d.sr = {tdi, s_q.sr[ACC_W-1:1]};
                else if (id_sel) s_d.sr = {{PAD_W{1'b0}}, tdi, s_q.sr[ID_W-1:1]};
                else             s_d.sr = {{(ACC_W-1){1'b0}}, tdi};
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) s_q <= '{ir: OP_IDCODE, ir_sr: '0, sr: '0};
        else         s_q <= s_d;
    end

    assign acc_cap_o = (state_i == TAP_CAP_DR) && acc_sel;
    assign acc_upd_o = (state_i == TAP_UP_DR) && acc_sel;
    assign is_ap_o   = (s_q.ir == OP_APACC);
    assign scan_o    = s_q.sr;
    assign tdo       = (state_i == TAP_SH_DR) ? s_q.sr[0] :
                       (state_i == TAP_SH_IR) ? s_q.ir_sr[0] : 1'b0;

    AST_IR_CAPTURE_VALUE: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == TAP_CAP_IR) |=> (s_q.ir_sr == IR_CAPTURE)); // R1
    AST_RESET_PICKS_ID: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == TAP_RESET) |=> (!is_ap_o && !acc_cap_o && !acc_upd_o)); // R1

endmodule

// File: rtl/jdp_dp_core.sv
module jdp_dp_core
    import jdp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int APSEL_W = 8,
    parameter int BANK_W  = 4
) (
    input  logic                       tck,
    input  logic                       trst_n,
    input  logic                       cap_i,
    input  logic                       upd_i,
    input  logic                       is_ap_i,
    input  logic                       rnw_i,
    input  logic [ADDR_W-1:0]          a_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [ACK_W-1:0]           ack_o,
    output logic [DATA_W-1:0]          rdbuf_o,
    output logic                       ap_req,
    output logic                       ap_wr,
    output logic [APSEL_W-1:0]         ap_sel,
    output logic [BANK_W+ADDR_W+1:0]   ap_addr,
    output logic [DATA_W-1:0]          ap_wdata,
    input  logic                       ap_ack,
    input  logic [DATA_W-1:0]          ap_rdata,
    input  logic                       ap_err,
    output logic                       sys_pwr_req,
    input  logic                       sys_pwr_ack,
    output logic                       dbg_pwr_req,
    input  logic                       dbg_pwr_ack
);

    localparam int AP_ADDR_W = BANK_W + ADDR_W + 2;

    typedef struct packed {
        logic [APSEL_W-1:0]   apsel;
        logic [BANK_W-1:0]    apbank;
        logic [BANK_W-1:0]    dpbank;
        logic                 sys_req;
        logic                 dbg_req;
        logic                 sticky;
        logic [DATA_W-1:0]    rbuf;
        logic                 stalled;
        logic                 busy;
        logic                 pend_rd;
        logic                 wr;
        logic [APSEL_W-1:0]   tsel;
        logic [AP_ADDR_W-1:0] taddr;
        logic [DATA_W-1:0]    twdata;
    } dp_t;

    dp_t               s_d, s_q;
    logic [DATA_W-1:0] ctrl_w, sel_w;

    always_comb begin
        ctrl_w             = '0;
        ctrl_w[DATA_W-1]   = sys_pwr_ack;
        ctrl_w[DATA_W-2]   = s_q.sys_req;
        ctrl_w[DATA_W-3]   = dbg_pwr_ack;
        ctrl_w[DATA_W-4]   = s_q.dbg_req;
        ctrl_w[STICKY_BIT] = s_q.sticky;
        sel_w                           = '0;
        sel_w[DATA_W-1 -: APSEL_W]      = s_q.apsel;
        sel_w[2*BANK_W-1 -: BANK_W]     = s_q.apbank;
        sel_w[BANK_W-1:0]               = s_q.dpbank;
    end

    always_comb begin
        s_d = s_q;
        if (s_q.busy && ap_ack) begin
            s_d.busy = 1'b0;
            if (ap_err)           s_d.sticky = 1'b1;
            else if (s_q.pend_rd) s_d.rbuf   = ap_rdata;
        end
        if (cap_i) s_d.stalled = s_q.busy;
        if (upd_i && !s_q.stalled) begin
            if (is_ap_i) begin
                if (!s_q.sticky) begin
                    s_d.busy    = 1'b1;
                    s_d.pend_rd = rnw_i;
                    s_d.wr      = !rnw_i;
                    s_d.tsel    = s_q.apsel;
                    s_d.taddr   = {s_q.apbank, a_i, 2'b00};
                    s_d.twdata  = wdata_i;
                end
            end else begin
                case (a_i)
                    2'd0: if (rnw_i) s_d.rbuf = '0;
                    2'd1: begin
                        if (s_q.dpbank != '0) begin
                            if (rnw_i) s_d.rbuf = '0;
                        end else if (rnw_i) begin
                            s_d.rbuf = ctrl_w;
                        end else begin
                            s_d.sys_req = wdata_i[DATA_W-2];
                            s_d.dbg_req = wdata_i[DATA_W-4];
                            if (wdata_i[STICKY_BIT]) s_d.sticky = 1'b0;
                        end
                    end
                    2'd2: begin
                        if (rnw_i) begin
                            s_d.rbuf = sel_w;
                        end else begin
                            s_d.apsel  = wdata_i[DATA_W-1 -: APSEL_W];
                            s_d.apbank = wdata_i[2*BANK_W-1 -: BANK_W];
                            s_d.dpbank = wdata_i[BANK_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ack_o       = s_q.busy ? ACK_WAIT : ACK_OK;
    assign rdbuf_o     = s_q.rbuf;
    assign ap_req      = s_q.busy;
    assign ap_wr       = s_q.wr;
    assign ap_sel      = s_q.tsel;
    assign ap_addr     = s_q.taddr;
    assign ap_wdata    = s_q.twdata;
    assign sys_pwr_req = s_q.sys_req;
    assign dbg_pwr_req = s_q.dbg_req;

    AST_REQ_HELD_STABLE: assert property (@(posedge tck) disable iff (!trst_n)
        (ap_req && !ap_ack) |=> (ap_req && $stable(ap_addr) && $stable(ap_sel) && $stable(ap_wdata))); // R8
    AST_REQ_DROPS_ON_ACK: assert property (@(posedge tck) disable iff (!trst_n)
        (ap_req && ap_ack) |=> !ap_req); // R8
    AST_STICKY_BLOCKS_BUS: assert property (@(posedge tck) disable iff (!trst_n)
        (s_q.sticky && !ap_req) |=> !ap_req); // R10

endmodule

// File: rtl/jtag_dp_engine.sv
module jtag_dp_engine
    import jdp_pkg::*;
#(
    parameter int        DATA_W  = 32,
    parameter int        APSEL_W = 8,
    parameter int        BANK_W  = 4,
    parameter logic [31:0] IDCODE = 32'h2C6A_90B3
) (
    input  logic                     tck,
    input  logic                     trst_n,
    input  logic                     tms,
    input  logic                     tdi,
    output logic                     tdo,
    output logic                     ap_req,
    output logic                     ap_wr,
    output logic [APSEL_W-1:0]       ap_sel,
    output logic [BANK_W+ADDR_W+1:0] ap_addr,
    output logic [DATA_W-1:0]        ap_wdata,
    input  logic                     ap_ack,
    input  logic [DATA_W-1:0]        ap_rdata,
    input  logic                     ap_err,
    output logic                     sys_pwr_req,
    input  logic                     sys_pwr_ack,
    output logic                     dbg_pwr_req,
    input  logic                     dbg_pwr_ack
);

    localparam int ACC_W = DATA_W + ACK_W;

    tap_state_e         tap_state;
    logic [ACK_W-1:0]   cap_ack;
    logic [DATA_W-1:0]  cap_data;
    logic               acc_cap, acc_upd, is_ap;
    logic [ACC_W-1:0]   scan;

    jdp_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (tap_state)
    );

    jdp_scan_path #(.DATA_W(DATA_W), .ID_W(32), .IDCODE(IDCODE)) u_scan (
        .tck        (tck),
        .trst_n     (trst_n),
        .state_i    (tap_state),
        .tdi        (tdi),
        .tdo        (tdo),
        .cap_ack_i  (cap_ack),
        .cap_data_i (cap_data),
        .acc_cap_o  (acc_cap),
        .acc_upd_o  (acc_upd),
        .is_ap_o    (is_ap),
        .scan_o     (scan)
    );

    jdp_dp_core #(.DATA_W(DATA_W), .APSEL_W(APSEL_W), .BANK_W(BANK_W)) u_dp (
        .tck         (tck),
        .trst_n      (trst_n),
        .cap_i       (acc_cap),
        .upd_i       (acc_upd),
        .is_ap_i     (is_ap),
        .rnw_i       (scan[0]),
        .a_i         (scan[ADDR_W:1]),
        .wdata_i     (scan[ACC_W-1:ACK_W]),
        .ack_o       (cap_ack),
        .rdbuf_o     (cap_data),
        .ap_req      (ap_req),
        .ap_wr       (ap_wr),
        .ap_sel      (ap_sel),
        .ap_addr     (ap_addr),
        .ap_wdata    (ap_wdata),
        .ap_ack      (ap_ack),
        .ap_rdata    (ap_rdata),
        .ap_err      (ap_err),
        .sys_pwr_req (sys_pwr_req),
        .sys_pwr_ack (sys_pwr_ack),
        .dbg_pwr_req (dbg_pwr_req),
        .dbg_pwr_ack (dbg_pwr_ack)
    );

    AST_WAIT_WHILE_OPEN: assert property (@(posedge tck) disable iff (!trst_n)
        (acc_cap && ap_req) |=> (scan[ACK_W-1:0] == ACK_WAIT)); // R4
    AST_OK_WHEN_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
        (acc_cap && !ap_req) |=> (scan[ACK_W-1:0] == ACK_OK)); // R3

endmodule

// File: tb/test_jtag_dp_engine.sv
module test_jtag_dp_engine;

    localparam logic [31:0] ID_EXP = 32'h2C6A_90B3;

    logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic        tdo, ap_req, ap_wr, sys_pwr_req, dbg_pwr_req;
    logic [7:0]  ap_sel, ap_addr;
    logic [31:0] ap_wdata;
    logic        ap_ack = 1'b0, ap_err = 1'b0;
    logic [31:0] ap_rdata = '0;
    logic        sys_pwr_ack = 1'b0, dbg_pwr_ack = 1'b0;

    jtag_dp_engine i_jtag_dp_engine (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .ap_req(ap_req), .ap_wr(ap_wr), .ap_sel(ap_sel), .ap_addr(ap_addr),
        .ap_wdata(ap_wdata), .ap_ack(ap_ack), .ap_rdata(ap_rdata), .ap_err(ap_err),
        .sys_pwr_req(sys_pwr_req), .sys_pwr_ack(sys_pwr_ack),
        .dbg_pwr_req(dbg_pwr_req), .dbg_pwr_ack(dbg_pwr_ack)
    );

    always #5 tck = ~tck;

    int n_tests = 0, n_fail = 0;
    int lat = 1, cnt = 0, xfers = 0;
    logic [7:0]  last_addr = '0, last_sel = '0;
    logic [31:0] apmem  [64];
    logic [31:0] refmem [64];
    logic [3:0]  cur_ir = 4'hE;

    // access-port bus model, fault at byte address 0xFC
    always @(posedge tck) begin
        sys_pwr_ack <= sys_pwr_req;
        dbg_pwr_ack <= dbg_pwr_req;
        if (ap_ack) begin
            ap_ack <= 1'b0;
            ap_err <= 1'b0;
        end else if (ap_req) begin
            if (cnt + 1 >= lat) begin
                ap_ack    <= 1'b1;
                cnt       <= 0;
                xfers     <= xfers + 1;
                last_addr <= ap_addr;
                last_sel  <= ap_sel;
                ap_err    <= (ap_addr == 8'hFC);
                ap_rdata  <= apmem[ap_addr[7:2]];
                if (ap_wr && ap_addr != 8'hFC) apmem[ap_addr[7:2]] <= ap_wdata;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        n_tests++; n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        summary();
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m; tdi = d;
        #1 o = tdo;
        @(posedge tck);
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
    endtask

    task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap);
        logic o;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, op[i], o);
            cap[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
        cur_ir = op;
    endtask

    task automatic dr_scan(input int n, input logic [34:0] din, output logic [34:0] dout);
        logic o;
        dout = '0;
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o);
            dout[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    task automatic acc(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] d,
                       output logic [2:0] ack, output logic [31:0] cap);
        logic [3:0]  c4;
        logic [34:0] dout;
        logic [3:0]  want;
        want = ap ? 4'hB : 4'hA;
        if (cur_ir != want) ir_scan(want, c4);
        dr_scan(35, {d, a, rnw}, dout);
        ack = dout[2:0];
        cap = dout[34:3];
        idle(8);
    endtask

    task automatic dp_read(input logic [1:0] a, output logic [31:0] v);
        logic [2:0]  k;
        logic [31:0] c;
        acc(0, 1, a, '0, k, c);
        acc(0, 1, 2'd3, '0, k, v);
    endtask

    initial begin
        logic [3:0]  c4;
        logic [34:0] dout;
        logic [2:0]  ack;
        logic [31:0] rd, rb_exp, sel_exp;
        int          x0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin
            apmem[i]  = 32'hA500_0000 + i;
            refmem[i] = 32'hA500_0000 + i;
        end
        repeat (3) @(posedge tck);
        @(negedge tck) trst_n = 1'b1;

        check("R9 reset sys req", sys_pwr_req, 0);
        check("R9 reset dbg req", dbg_pwr_req, 0);
        check("R8 reset ap_req", ap_req, 0);

        idle(1);
        dr_scan(32, '0, dout);
        check("R2 idcode after reset (R1 reset opcode)", dout[31:0], ID_EXP);

        ir_scan(4'h3, c4);
        check("R1 IR capture", c4, 4'b0001);
        dr_scan(8, 35'h0B6, dout);
        check("R2 bypass on unlisted opcode (R1)", dout[7:0], 8'h6C);
        ir_scan(4'hF, c4);
        dr_scan(8, 35'h0C5, dout);
        check("R2 bypass opcode", dout[7:0], 8'h8A);

        // power handshake
        acc(0, 0, 2'd1, 32'h5000_0000, ack, rd);
        check("R3 ack ok", ack, 3'b010);
        check("R9 sys req pin", sys_pwr_req, 1);
        check("R9 dbg req pin", dbg_pwr_req, 1);
        dp_read(2'd1, rd);
        check("R9 ctrl readback", rd, 32'hF000_0000);

        // banked control/status
        acc(0, 0, 2'd2, 32'h0000_0001, ack, rd);
        dp_read(2'd1, rd);
        check("R5 bank1 reads zero", rd, 0);
        acc(0, 0, 2'd1, 32'h0000_0000, ack, rd);
        check("R5 bank1 write ignored", sys_pwr_req, 1);
        dp_read(2'd0, rd);
        check("R5 addr0 reads zero", rd, 0);
        acc(0, 0, 2'd2, 32'h5A00_0030, ack, rd);
        dp_read(2'd1, rd);
        check("R5 bank0 ctrl", rd, 32'hF000_0000);
        dp_read(2'd2, rd);
        check("R6 select readback", rd, 32'h5A00_0030);

        // posted reads and bus addressing
        x0 = xfers;
        acc(1, 0, 2'd2, 32'h1234_5678, ack, rd);
        refmem[6'h0E] = 32'h1234_5678;
        check("R6 ap_addr", last_addr, 8'h38);
        check("R6 ap_sel", last_sel, 8'h5A);
        check("R8 one transfer", xfers - x0, 1);
        acc(1, 0, 2'd1, 32'h0BAD_F00D, ack, rd);
        refmem[6'h0D] = 32'h0BAD_F00D;
        acc(1, 1, 2'd2, '0, ack, rd);
        x0 = xfers;
        acc(0, 1, 2'd3, '0, ack, rd);
        check("R7 rdbuf returns posted read", rd, 32'h1234_5678);
        acc(0, 1, 2'd3, '0, ack, rd);
        check("R7 rdbuf repeat", rd, 32'h1234_5678);
        check("R7 rdbuf makes no transfer", xfers - x0, 0);
        acc(1, 1, 2'd1, '0, ack, rd);
        acc(1, 1, 2'd2, '0, ack, rd);
        check("R7 capture is previous ap read", rd, 32'h0BAD_F00D);

        // WAIT and discard
        lat = 60;
        x0 = xfers;
        acc(1, 0, 2'd0, 32'hDEAD_0001, ack, rd);
        acc(1, 0, 2'd0, 32'hBEEF_0002, ack, rd);
        check("R4 wait ack", ack, 3'b001);
        idle(80);
        lat = 1;
        check("R4 discarded scan no transfer", xfers - x0, 1);
        acc(1, 1, 2'd0, '0, ack, rd);
        acc(0, 1, 2'd3, '0, ack, rd);
        check("R4 first write kept", rd, 32'hDEAD_0001);
        refmem[6'h0C] = 32'hDEAD_0001;

        // sticky error
        acc(0, 0, 2'd2, 32'h5A00_00F0, ack, rd);
        acc(1, 0, 2'd3, 32'h1111_1111, ack, rd);
        dp_read(2'd1, rd);
        check("R10 sticky set", rd, 32'hF000_0020);
        x0 = xfers;
        acc(1, 1, 2'd0, '0, ack, rd);
        check("R10 ack ok while sticky", ack, 3'b010);
        acc(1, 0, 2'd1, 32'h2222_2222, ack, rd);
        check("R10 no transfer while sticky", xfers - x0, 0);
        acc(0, 1, 2'd3, '0, ack, rd);
        check("R10 read buffer unchanged", rd, 32'hF000_0020);
        acc(0, 0, 2'd1, 32'h5000_0020, ack, rd);
        dp_read(2'd1, rd);
        check("R10 sticky cleared", rd, 32'hF000_0000);
        acc(1, 1, 2'd0, '0, ack, rd);
        check("R10 transfers resume", xfers - x0, 1);

        // random mix
        sel_exp = 32'h0000_0000;
        acc(0, 0, 2'd2, sel_exp, ack, rd);
        dp_read(2'd2, rd);
        rb_exp = sel_exp;
        for (int it = 0; it < 60; it++) begin
            int          op;
            logic [1:0]  a;
            logic [31:0] d;
            logic [5:0]  idx;
            op  = $urandom % 5;
            a   = 2'($urandom);
            d   = $urandom;
            lat = 1 + ($urandom % 4);
            idx = {sel_exp[7:4], a};
            case (op)
                0: acc(1, 0, a, d, ack, rd);
                1: acc(1, 1, a, '0, ack, rd);
                2: begin
                    d = {8'($urandom), 16'h0, 2'b00, 2'($urandom), 4'h0};
                    acc(0, 0, 2'd2, d, ack, rd);
                end
                3: acc(0, 1, 2'd2, '0, ack, rd);
                default: acc(0, 1, 2'd3, '0, ack, rd);
            endcase
            check("R3 random ack", ack, 3'b010);
            check("R3 random capture (R5 R7)", rd, rb_exp);
            case (op)
                0: refmem[idx] = d;
                1: rb_exp = refmem[idx];
                2: sel_exp = d;
                3: rb_exp = sel_exp;
                default: ;
            endcase
        end
        acc(0, 1, 2'd3, '0, ack, rd);
        check("R6 random final (R7)", rd, rb_exp);
        summary();
    end

endmodule